// File: doc/BRIEF.md
# Multiply-Step Datapath

This block performs one iteration of a shift-and-add multiply. Each accepted step takes an accumulator operand, a multiplicand operand, the current multiplier-shift register and the sign and overflow flags from the previous step. It makes a right-shifted partial value whose new top bit is the true sign of the previous sum. It adds the multiplicand to that partial value only when the low bit of the shift register is set. It also shifts the accumulator's low bit into the top of the shift register. The sum, the updated shift register and two sets of condition flags appear one clock after the step is presented. The flags are computed on the low 32 bits and on the full 64 bits.

A sequencer outside the block issues the steps. It feeds each result back as the next accumulator operand, feeds the new shift-register value back as the next shift-register input, and returns the low-word N and V flags. Register storage also sits outside the block. The sequencer starts with the multiplier in the shift register and an accumulator of zero, then issues 32 steps with the multiplicand followed by one step with a zero multiplicand. At the end the result holds the high word of the product and the shift register holds the low word.

Top module: `msu_top`

## Requirements
- R1: While rst_n is low at a clock edge, every output register clears: step_vld_o is 0, and rd_o, y_o, icc_o and xcc_o are all zero.
- R2: A step presented with step_vld_i high at one edge appears on the outputs after that edge, with step_vld_o high for exactly that cycle. When step_vld_i is low, step_vld_o drops and rd_o, y_o, icc_o and xcc_o keep their values.
- R3: The partial value is 64 bits wide. Bits 30:0 are op_a_i bits 31:1, bit 31 is icc_n_i XOR icc_v_i, and bits 63:32 are zero.
- R4: The addend is op_b_i when y_i bit 0 is 1, and zero when y_i bit 0 is 0.
- R5: rd_o is the 64-bit sum of the addend and the partial value, taken modulo 2^64.
- R6: y_o is y_i shifted right by one place, with op_a_i bit 0 placed in bit 31.
- R7: The icc V flag, icc_o bit 1, is set when bit 31 of the addend equals bit 31 of the partial value and bit 31 of the sum differs from both.
- R8: The icc C flag, icc_o bit 0, is the carry out of bit 31 when the low 32 bits of the addend and the partial value are added.
- R9: The icc N flag, icc_o bit 3, is sum bit 31. The icc Z flag, icc_o bit 2, is set when sum bits 31:0 are all zero.
- R10: xcc_o uses the same bit order (N in bit 3, Z in bit 2, V in bit 1, C in bit 0), computed on the full 64 bits: N is bit 63, Z is set for an all-zero sum, V uses bit 63, and C is the carry out of bit 63.
- R11: Start with y_i equal to a multiplier, op_a_i equal to 0 and both flags 0. Run 32 steps with the multiplicand on op_b_i, then one step with op_b_i equal to 0, each step taking the previous rd_o, y_o, icc N and icc V as its inputs. For a multiplicand below 2^30, rd_o bits 31:0 then hold the high word of the product and y_o holds the low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_vld_i | input | 1 | A step is presented this cycle |
| op_a_i | input | 64 | Accumulator operand; its low 32 bits are shifted |
| op_b_i | input | 64 | Multiplicand operand |
| y_i | input | 32 | Current multiplier-shift register |
| icc_n_i | input | 1 | Previous low-word sign flag |
| icc_v_i | input | 1 | Previous low-word overflow flag |
| step_vld_o | output | 1 | Result of a step is on the outputs |
| rd_o | output | 64 | Step sum |
| y_o | output | 32 | Updated multiplier-shift register |
| icc_o | output | 4 | Low-word flags {N,Z,V,C} |
| xcc_o | output | 4 | Full-width flags {N,Z,V,C} |

## Verification
The assertions assume the inputs are stable and known at each clock edge while step_vld_i is high. They also assume that a result is only compared against the step accepted in the cycle just before it. The bench drives every input on the falling edge and holds it across the rising edge, and it drops step_vld_i between steps so that the hold behaviour can be seen. The 33-step product check feeds the outputs back as inputs and uses multiplicands below 2^30. In that range no intermediate sum reaches bit 31, so the sign and overflow flags returned to the block stay consistent with an unsigned product.

// File: rtl/msu_pkg.sv
// Package: shared types and widths for the multiply-step datapath.
// Assumes a flag vector ordered {N,Z,V,C} from bit 3 down to bit 0.
package msu_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } msu_cc_t;

    localparam int unsigned CC_W = 4;

endpackage

// File: rtl/msu_prep.sv
// msu_prep: forms the shifted partial value, the gated addend and the new
// shift-register value for one step. Purely combinational.
// Assumes DW is twice HW and HW is at least 2.
module msu_prep #(
    parameter int unsigned DW = 64,
    parameter int unsigned HW = DW / 2
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [HW-1:0] y_cur,
    input  logic          sgn_n,
    input  logic          sgn_v,
    output logic [DW-1:0] partial,
    output logic [DW-1:0] addend,
    output logic [HW-1:0] y_next
);
    localparam int unsigned UPW = DW - HW;

    // Partial: low word shifted right, true sign of the last sum on top.
    always_comb begin
        partial = {{UPW{1'b0}}, (sgn_n ^ sgn_v), op_a[HW-1:1]};
    end

    // Addend: the multiplicand only when the current multiplier bit is set.
    always_comb begin
        addend = y_cur[0] ? op_b : '0;
    end

    // Shift register: the accumulator's low bit enters at the top.
    always_comb begin
        y_next = {op_a[0], y_cur[HW-1:1]};
    end

endmodule

// File: rtl/msu_addflag.sv
// msu_addflag: W-bit adder that also produces N, Z, V and C flags.
// Assumes unsigned wraparound for the sum; V follows two's-complement rules.
module msu_addflag
    import msu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output msu_cc_t      cc
);
    localparam int unsigned MSB = W - 1;

    logic [W:0] wide;

    // Sum with carry out in one extra bit.
    always_comb begin
        wide = {1'b0, a} + {1'b0, b};
        sum  = wide[W-1:0];
    end

    // Flags derived from the operands and the sum.
    always_comb begin
        cc.n = wide[MSB];
        cc.z = (wide[W-1:0] == '0);
        cc.v = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
        cc.c = wide[W];
    end

endmodule

// File: rtl/msu_top.sv
// msu_top: one registered multiply step. A step presented at one edge has
// its sum, new shift register and both flag sets on the outputs after it.
// Assumes the sequencer feeds results back; outputs hold when idle.
module msu_top
    import msu_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned HW = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_vld_i,
    input  logic [DW-1:0] op_a_i,
    input  logic [DW-1:0] op_b_i,
    input  logic [HW-1:0] y_i,
    input  logic          icc_n_i,
    input  logic          icc_v_i,
    output logic          step_vld_o,
    output logic [DW-1:0] rd_o,
    output logic [HW-1:0] y_o,
    output logic [3:0]    icc_o,
    output logic [3:0]    xcc_o
);
    localparam int unsigned NUM_VIEWS = 2;

    logic [DW-1:0] partial;
    logic [DW-1:0] addend;
    logic [HW-1:0] y_next;
    logic [DW-1:0] sum_full;
    logic [HW-1:0] sum_low;
    msu_cc_t       cc_view [NUM_VIEWS];

    msu_prep #(.DW(DW), .HW(HW)) prep_i (
        .op_a    (op_a_i),
        .op_b    (op_b_i),
        .y_cur   (y_i),
        .sgn_n   (icc_n_i),
        .sgn_v   (icc_v_i),
        .partial (partial),
        .addend  (addend),
        .y_next  (y_next)
    );

    // View 0 flags the low word, view 1 the full width.
    for (genvar g = 0; g < NUM_VIEWS; g++) begin : g_view
        if (g == 0) begin : g_low
            msu_addflag #(.W(HW)) add_i (
                .a   (addend[HW-1:0]),
                .b   (partial[HW-1:0]),
                .sum (sum_low),
                .cc  (cc_view[g])
            );
        end else begin : g_full
            msu_addflag #(.W(DW)) add_i (
                .a   (addend),
                .b   (partial),
                .sum (sum_full),
                .cc  (cc_view[g])
            );
        end
    end

    // Output register: loads on an accepted step, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_vld_o <= 1'b0;
            rd_o       <= '0;
            y_o        <= '0;
            icc_o      <= '0;
            xcc_o      <= '0;
        end else begin
            step_vld_o <= step_vld_i;
            if (step_vld_i) begin
                rd_o  <= sum_full;
                y_o   <= y_next;
                icc_o <= cc_view[0];
                xcc_o <= cc_view[1];
            end
        end
    end

    // R2: an accepted step shows up one cycle later.
    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld_i |=> step_vld_o);

    // R2: idle cycles leave the result untouched.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_vld_i |=> ($stable(rd_o) && $stable(y_o) && $stable(icc_o)));

    // R6: the shift register moves right, taking the accumulator's low bit.
    assert_y_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld_i |=> (y_o == {$past(op_a_i[0]), $past(y_i[HW-1:1])}));

    // R4: with the multiplier bit clear the result is just the partial value.
    assert_gated_addend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld_i && !y_i[0]) |=>
        (rd_o == {{(DW-HW){1'b0}}, ($past(icc_n_i) ^ $past(icc_v_i)), $past(op_a_i[HW-1:1])}));

    // R9: the low-word Z flag agrees with the registered result.
    assert_icc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld_o |-> (icc_o[2] == (rd_o[HW-1:0] == '0)));

    // R10: full-width N and Z agree with the registered result.
    assert_xcc_nz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld_o |-> ((xcc_o[3] == rd_o[DW-1]) && (xcc_o[2] == (rd_o == '0))));

endmodule

// File: tb/msu_top_tb.sv
module msu_top_tb_top;
    localparam int DW = 64;
    localparam int HW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_vld_i = 1'b0;
    logic [DW-1:0] op_a_i = '0;
    logic [DW-1:0] op_b_i = '0;
    logic [HW-1:0] y_i = '0;
    logic          icc_n_i = 1'b0;
    logic          icc_v_i = 1'b0;
    logic          step_vld_o;
    logic [DW-1:0] rd_o;
    logic [HW-1:0] y_o;
    logic [3:0]    icc_o;
    logic [3:0]    xcc_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    msu_top #(.DW(DW), .HW(HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_vld_i(step_vld_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .y_i(y_i),
        .icc_n_i(icc_n_i), .icc_v_i(icc_v_i),
        .step_vld_o(step_vld_o), .rd_o(rd_o), .y_o(y_o),
        .icc_o(icc_o), .xcc_o(xcc_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        case (i)
            0: pat = 64'h0;
            1: pat = 64'h1;
            2: pat = 64'hFFFF_FFFF_FFFF_FFFF;
            3: pat = 64'h0000_0000_7FFF_FFFF;
            4: pat = 64'h0000_0000_8000_0000;
            5: pat = 64'h0000_0000_FFFF_FFFE;
            6: pat = 64'h0000_0001_0000_0003;
            7: pat = 64'h8000_0000_0000_0001;
            8: pat = 64'h7FFF_FFFF_FFFF_FFFF;
            default: pat = 64'hA5C3_0F96_5A3C_F069;
        endcase
    endfunction

    // Apply one step, then sample after the capturing edge.
    task automatic do_step(input logic [DW-1:0] a, input logic [DW-1:0] b,
                           input logic [HW-1:0] y, input logic n, input logic v);
        @(negedge clk);
        op_a_i = a; op_b_i = b; y_i = y; icc_n_i = n; icc_v_i = v;
        step_vld_i = 1'b1;
        @(negedge clk);
        step_vld_i = 1'b0;
    endtask

    // Step sweep with expectations from R3..R10.
    task automatic sweep_check(input logic [DW-1:0] a, input logic [DW-1:0] b,
                               input logic [HW-1:0] y, input logic n, input logic v);
        logic [DW-1:0] part, add, s;
        logic [HW:0]   s32;
        logic [DW:0]   s64;
        logic [3:0]    ei, ex;
        part = {32'h0, n ^ v, a[31:1]};
        add  = y[0] ? b : 64'h0;
        s64  = {1'b0, add} + {1'b0, part};
        s    = s64[DW-1:0];
        s32  = {1'b0, add[31:0]} + {1'b0, part[31:0]};
        ei = {s[31], (s[31:0] == 0), (add[31] == part[31]) && (s[31] != add[31]), s32[32]};
        ex = {s[63], (s == 0), (add[63] == part[63]) && (s[63] != add[63]), s64[64]};
        do_step(a, b, y, n, v);
        chk("R2 valid", {63'h0, step_vld_o}, 64'h1);
        chk("R3/R4/R5 result", rd_o, s);
        chk("R6 y", {32'h0, y_o}, {32'h0, a[0], y[31:1]});
        chk("R7 icc V", {63'h0, icc_o[1]}, {63'h0, ei[1]});
        chk("R8 icc C", {63'h0, icc_o[0]}, {63'h0, ei[0]});
        chk("R9 icc N,Z", {62'h0, icc_o[3:2]}, {62'h0, ei[3:2]});
        chk("R10 xcc", {60'h0, xcc_o}, {60'h0, ex});
        @(negedge clk);
        chk("R2 idle valid", {63'h0, step_vld_o}, 64'h0);
        chk("R2 idle hold", rd_o, s);
    endtask

    // R11: 33-step product sequence with outputs fed back.
    task automatic product_check(input logic [31:0] mcand, input logic [31:0] mplier);
        logic [DW-1:0] acc;
        logic [HW-1:0] y;
        logic          n, v;
        logic [63:0]   prod;
        acc = 0; y = mplier; n = 0; v = 0;
        for (int k = 0; k < 33; k++) begin
            do_step(acc, (k < 32) ? {32'h0, mcand} : 64'h0, y, n, v);
            acc = rd_o; y = y_o; n = icc_o[3]; v = icc_o[1];
        end
        prod = {32'h0, mcand} * {32'h0, mplier};
        chk("R11 product high", {32'h0, acc[31:0]}, {32'h0, prod[63:32]});
        chk("R11 product low", {32'h0, y}, {32'h0, prod[31:0]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R1: apply stimulus during reset and confirm the cleared state.
        step_vld_i = 1'b1; op_a_i = '1; op_b_i = '1; y_i = '1;
        repeat (3) @(negedge clk);
        chk("R1 valid", {63'h0, step_vld_o}, 64'h0);
        chk("R1 rd", rd_o, 64'h0);
        chk("R1 y", {32'h0, y_o}, 64'h0);
        chk("R1 flags", {56'h0, icc_o, xcc_o}, 64'h0);
        step_vld_i = 1'b0;
        rst_n = 1'b1;

        // R3..R10 sweep: operand patterns, every N/V pair, both multiplier bits.
        for (int ia = 0; ia < 10; ia++)
            for (int ib = 0; ib < 10; ib++)
                for (int nv = 0; nv < 4; nv++)
                    for (int yb = 0; yb < 2; yb++)
                        sweep_check(pat(ia), pat(ib),
                                    {pat(ib + ia)[31:1], yb[0]} ^ 32'h9000_0000,
                                    nv[1], nv[0]);

        // R11: several multiplicand/multiplier pairs.
        product_check(32'd5, 32'd1);
        product_check(32'd12345, 32'd6789);
        product_check(32'h3FFF_FFFF, 32'hFFFF_FFFF);
        product_check(32'h2AAA_5555, 32'h8000_0001);
        product_check(32'd0, 32'hDEAD_BEEF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule